// File: doc/BRIEF.md
# Stack Burst Sequencer for Multi-Register Save and Restore

This block carries out one instruction that moves a chosen set of general registers to or from the stack. It receives a start pulse, a direction bit, a 16-bit selection mask and the current stack pointer. It then visits the selected registers one per memory access. On each access it drives the register-file read or write port and a single-port memory request, and it moves the stack pointer by one word.

A save visits registers from the highest index down to the lowest. Before each store it lowers the stack pointer by one word. A restore visits them from the lowest index up and raises the stack pointer by one word after each load. A restore with the same mask therefore undoes a save exactly. While the burst runs, the block raises an interrupt-hold output, so the whole transfer retires before an interrupt is taken. At the end it gives a one-cycle completion pulse and the final stack pointer.

Top module: `stack_burst_seq`

## Requirements
- R1: While reset is held, busy, done, intInhibit, memReq and rfWrEn are all low.
- R2: For a save (isPop=0), the accesses visit the selected registers from the highest index to the lowest. Each access has memWe=1, rfRdIdx set to the register, memAddr equal to the current stack pointer minus 4, and memWdata equal to that register's value.
- R3: For a restore (isPop=1), the accesses visit the selected registers from the lowest index to the highest. Each access has memWe=0 and memAddr equal to the current stack pointer. rfWrIdx is the register and rfWrData equals memRdata. rfWrEn is high exactly when memReady is high.
- R4: When done pulses, spOut equals spIn minus 4 times the number of selected registers for a save, or plus that amount for a restore.
- R5: At most one access is presented per cycle. While memReady is low, the same access stays on the outputs and neither the stack pointer nor the remaining set advances.
- R6: An all-zero mask raises done in the cycle after the start edge, with spOut equal to spIn. No memory request is made and busy does not rise.
- R7: busy is high from the cycle after the start edge through the cycle in which the last access is accepted, and intInhibit always equals busy.
- R8: A start pulse that arrives while busy is high is ignored, and the running burst continues unchanged.
- R9: A restore with the same mask, issued after a save and starting from the stack pointer the save produced, returns every selected register to its saved value and the stack pointer to its starting value.
- R10: done is high for exactly one cycle per instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startI | input | 1 | Start pulse, taken when idle |
| isPop | input | 1 | 1 = restore from stack, 0 = save to stack |
| regMask | input | 16 | Register selection, bit i selects register i |
| spIn | input | 32 | Stack pointer at start |
| memReady | input | 1 | Memory accepts the access this cycle |
| memReq | output | 1 | Memory access request |
| memWe | output | 1 | 1 = store, 0 = load |
| memAddr | output | 32 | Word-aligned byte address |
| memWdata | output | 32 | Store data |
| memRdata | input | 32 | Load data, valid with memReady |
| rfRdIdx | output | 4 | Register-file read index |
| rfRdData | input | 32 | Register-file read data, combinational |
| rfWrEn | output | 1 | Register-file write enable |
| rfWrIdx | output | 4 | Register-file write index |
| rfWrData | output | 32 | Register-file write data |
| busy | output | 1 | Burst in progress |
| intInhibit | output | 1 | Interrupt acceptance held off |
| done | output | 1 | One-cycle completion pulse |
| spOut | output | 32 | Final stack pointer, valid with done |

## Verification
The first access appears in the cycle right after the start edge. Each later access appears one edge after its predecessor was accepted, and an access repeats for every cycle in which memReady is low. done and the final spOut come one edge after the last accepted access, or one edge after the start edge for an empty mask. The bench drives inputs at the falling edge, waits one time unit, and compares in that same half cycle. The expected register index, address and pointer for that cycle come from its own copy of the remaining mask, which it advances only in cycles where it drove memReady high.

// File: rtl/stk_pkg.sv
package stk_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic load;   // capture mask, direction and pointer
    logic step;   // one access accepted, advance
  } stkStrobe_t;
endpackage

// File: rtl/stk_dpath.sv
module stk_dpath
  import stk_pkg::*;
#(
  parameter int NUM_REGS   = 16,
  parameter int ADDR_W     = 32,
  parameter int WORD_BYTES = 4,
  parameter int IDX_W      = $clog2(NUM_REGS)
) (
  input  logic                clk,
  input  logic                rstN,
  input  stkStrobe_t          strb,
  input  logic                isPop,
  input  logic [NUM_REGS-1:0] regMask,
  input  logic [ADDR_W-1:0]   spIn,
  output logic [IDX_W-1:0]    curIdx,
  output logic                lastOne,
  output logic                popMode,
  output logic [ADDR_W-1:0]   spCur,
  output logic [ADDR_W-1:0]   accAddr
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_BYTES);

  logic [NUM_REGS-1:0] pendMask;

  // Pick next register: lowest for restore, highest for save
  always_comb begin
    curIdx = '0;
    if (popMode) begin
      for (int i = NUM_REGS - 1; i >= 0; i--)
        if (pendMask[i]) curIdx = IDX_W'(i);
    end else begin
      for (int i = 0; i < NUM_REGS; i++)
        if (pendMask[i]) curIdx = IDX_W'(i);
    end
  end

  assign lastOne = $onehot(pendMask);
  assign accAddr = popMode ? spCur : spCur - STEP;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendMask <= '0;
      popMode  <= 1'b0;
      spCur    <= '0;
    end else if (strb.load) begin
      pendMask <= regMask;
      popMode  <= isPop;
      spCur    <= spIn;
    end else if (strb.step) begin
      pendMask[curIdx] <= 1'b0;
      spCur            <= popMode ? spCur + STEP : spCur - STEP;
    end
  end

  // R5
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.load && !strb.step) |=> ($stable(spCur) && $stable(pendMask)));
  // R2
  save_predec_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.step && !strb.load && !popMode) |=> (spCur == $past(spCur) - STEP));
  // R3
  restore_postinc_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.step && !strb.load && popMode) |=> (spCur == $past(spCur) + STEP));
  // R5
  one_per_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.step && !strb.load) |=> ($countones(pendMask) == $countones($past(pendMask)) - 1));
endmodule

// File: rtl/stk_ctrl.sv
module stk_ctrl
  import stk_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startI,
  input  logic       maskAny,
  input  logic       memReady,
  input  logic       lastOne,
  output stkStrobe_t strb,
  output logic       busy,
  output logic       done
);
  always_comb begin
    strb.load = startI & ~busy;   // start ignored while busy
    strb.step = busy & memReady;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (strb.load) begin
        busy <= maskAny;
        done <= ~maskAny;
      end else if (strb.step && lastOne) begin
        busy <= 1'b0;
        done <= 1'b1;
      end
    end
  end

  // R6
  empty_mask_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.load && !maskAny) |=> (done && !busy));
  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  // R7
  busy_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done);
  // R8
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && startI && !memReady) |=> busy);
endmodule

// File: rtl/stack_burst_seq.sv
module stack_burst_seq
  import stk_pkg::*;
#(
  parameter int NUM_REGS   = 16,
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 32,
  parameter int WORD_BYTES = 4,
  parameter int IDX_W      = $clog2(NUM_REGS)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                startI,
  input  logic                isPop,
  input  logic [NUM_REGS-1:0] regMask,
  input  logic [ADDR_W-1:0]   spIn,
  input  logic                memReady,
  output logic                memReq,
  output logic                memWe,
  output logic [ADDR_W-1:0]   memAddr,
  output logic [DATA_W-1:0]   memWdata,
  input  logic [DATA_W-1:0]   memRdata,
  output logic [IDX_W-1:0]    rfRdIdx,
  input  logic [DATA_W-1:0]   rfRdData,
  output logic                rfWrEn,
  output logic [IDX_W-1:0]    rfWrIdx,
  output logic [DATA_W-1:0]   rfWrData,
  output logic                busy,
  output logic                intInhibit,
  output logic                done,
  output logic [ADDR_W-1:0]   spOut
);
  stkStrobe_t          strb;
  logic [IDX_W-1:0]    curIdx;
  logic                lastOne;
  logic                popMode;
  logic [ADDR_W-1:0]   spCur;
  logic [ADDR_W-1:0]   accAddr;

  stk_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .startI   (startI),
    .maskAny  (|regMask),
    .memReady (memReady),
    .lastOne  (lastOne),
    .strb     (strb),
    .busy     (busy),
    .done     (done)
  );

  stk_dpath #(
    .NUM_REGS   (NUM_REGS),
    .ADDR_W     (ADDR_W),
    .WORD_BYTES (WORD_BYTES),
    .IDX_W      (IDX_W)
  ) u_dpath (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .isPop   (isPop),
    .regMask (regMask),
    .spIn    (spIn),
    .curIdx  (curIdx),
    .lastOne (lastOne),
    .popMode (popMode),
    .spCur   (spCur),
    .accAddr (accAddr)
  );

  assign memReq     = busy;
  assign memWe      = busy & ~popMode;
  assign memAddr    = accAddr;
  assign memWdata   = rfRdData;
  assign rfRdIdx    = curIdx;
  assign rfWrEn     = busy & popMode & memReady;
  assign rfWrIdx    = curIdx;
  assign rfWrData   = memRdata;
  assign intInhibit = busy;
  assign spOut      = spCur;

  // R5
  no_write_on_stall_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !memReady) |-> !rfWrEn);
endmodule

// File: tb/test_stack_burst_seq.sv
module test_stack_burst_seq;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startI = 1'b0;
  logic        isPop = 1'b0;
  logic [15:0] regMask = '0;
  logic [31:0] spIn = '0;
  logic        memReady = 1'b1;
  logic        memReq, memWe, rfWrEn, busy, intInhibit, done;
  logic [31:0] memAddr, memWdata, memRdata, rfRdData, rfWrData, spOut;
  logic [3:0]  rfRdIdx, rfWrIdx;

  logic [31:0] regs [16];
  logic [31:0] mem [64];
  logic        scrub = 1'b0;
  logic [15:0] scrubMask = '0;
  int nChk = 0;
  int nBad = 0;

  always #10 clk = ~clk;   // 50 MHz

  stack_burst_seq i_stack_burst_seq (
    .clk(clk), .rstN(rstN), .startI(startI), .isPop(isPop), .regMask(regMask),
    .spIn(spIn), .memReady(memReady), .memReq(memReq), .memWe(memWe),
    .memAddr(memAddr), .memWdata(memWdata), .memRdata(memRdata),
    .rfRdIdx(rfRdIdx), .rfRdData(rfRdData), .rfWrEn(rfWrEn), .rfWrIdx(rfWrIdx),
    .rfWrData(rfWrData), .busy(busy), .intInhibit(intInhibit), .done(done),
    .spOut(spOut)
  );

  function automatic logic [31:0] seedVal(input int i);
    return 32'hC0DE_0000 + 32'(i) * 32'h0101_0011;
  endfunction

  assign rfRdData = regs[rfRdIdx];
  assign memRdata = mem[memAddr[7:2]];

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 16; i++) regs[i] <= seedVal(i);
    end else begin
      if (scrub)
        for (int i = 0; i < 16; i++) if (scrubMask[i]) regs[i] <= 32'hDEAD_BEEF;
      if (rfWrEn) regs[rfWrIdx] <= rfWrData;
    end
    if (memReq && memReady && memWe) mem[memAddr[7:2]] <= memWdata;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int pickIdx(input logic [15:0] m, input logic pop);
    int r = 0;
    if (pop) begin
      for (int i = 15; i >= 0; i--) if (m[i]) r = i;
    end else begin
      for (int i = 0; i < 16; i++) if (m[i]) r = i;
    end
    return r;
  endfunction

  task automatic runBurst(input logic pop, input logic [15:0] m, input logic [31:0] sp,
                          input logic stall, input logic poke);
    logic [15:0] pend = m;
    logic [31:0] expSp = sp;
    int cyc = 0;
    int idx;
    @(negedge clk);
    startI = 1'b1; isPop = pop; regMask = m; spIn = sp; memReady = 1'b1;
    @(negedge clk);
    startI = 1'b0; regMask = '0;
    if (m == 16'h0) begin
      #1;
      chk("R6 done", 32'(done), 1);
      chk("R6 busy", 32'(busy), 0);
      chk("R6 memReq", 32'(memReq), 0);
      chk("R6 spOut", spOut, sp);
      @(negedge clk); #1;
      chk("R10 done drop", 32'(done), 0);
      return;
    end
    while (pend != 16'h0 && cyc < 200) begin
      memReady = !(stall && (cyc % 3 == 1));
      if (poke && cyc == 1) begin
        startI = 1'b1; regMask = 16'hFFFF; isPop = ~pop; spIn = 32'h0;   // R8 poke
      end else begin
        startI = 1'b0;
      end
      #1;
      idx = pickIdx(pend, pop);
      chk("R7 busy", 32'(busy), 1);
      chk("R7 intInhibit", 32'(intInhibit), 1);
      chk("R5 memReq", 32'(memReq), 1);
      chk("R10 done low", 32'(done), 0);
      if (!pop) begin
        chk("R2 memWe", 32'(memWe), 1);
        chk("R2 rfRdIdx", 32'(rfRdIdx), 32'(idx));
        chk("R2 memAddr", memAddr, expSp - 32'd4);
        chk("R2 memWdata", memWdata, seedVal(idx));
      end else begin
        chk("R3 memWe", 32'(memWe), 0);
        chk("R3 rfWrIdx", 32'(rfWrIdx), 32'(idx));
        chk("R3 memAddr", memAddr, expSp);
        chk("R3 rfWrEn", 32'(rfWrEn), 32'(memReady));
        chk("R3 rfWrData", rfWrData, mem[expSp[7:2]]);
      end
      if (memReady) begin
        pend[idx] = 1'b0;
        expSp = pop ? expSp + 32'd4 : expSp - 32'd4;
      end
      cyc++;
      @(negedge clk);
    end
    startI = 1'b0; memReady = 1'b1; #1;
    chk("R10 done", 32'(done), 1);
    chk("R7 busy end", 32'(busy), 0);
    chk("R7 intInhibit end", 32'(intInhibit), 0);
    chk("R4 spOut", spOut, pop ? sp + 32'($countones(m)) * 4 : sp - 32'($countones(m)) * 4);
    @(negedge clk); #1;
    chk("R10 done one cycle", 32'(done), 0);
    chk("R5 memReq idle", 32'(memReq), 0);
  endtask

  task automatic roundTrip(input logic [15:0] m, input logic [31:0] sp,
                           input logic stall, input logic poke);
    logic [31:0] low = sp - 32'($countones(m)) * 4;
    runBurst(1'b0, m, sp, stall, poke);
    @(negedge clk); scrub = 1'b1; scrubMask = m;
    @(negedge clk); scrub = 1'b0;
    runBurst(1'b1, m, low, ~stall, poke);
    chk("R9 spOut", spOut, sp);
    for (int i = 0; i < 16; i++) chk("R9 register", regs[i], seedVal(i));
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    #1;
    chk("R1 busy", 32'(busy), 0);
    chk("R1 done", 32'(done), 0);
    chk("R1 intInhibit", 32'(intInhibit), 0);
    chk("R1 memReq", 32'(memReq), 0);
    chk("R1 rfWrEn", 32'(rfWrEn), 0);
    rstN = 1'b1;
    // R6 empty masks in both directions
    runBurst(1'b0, 16'h0, 32'h0000_0200, 1'b0, 1'b0);
    runBurst(1'b1, 16'h0, 32'h0000_0344, 1'b0, 1'b0);
    // single-register sweep
    for (int s = 0; s < 16; s++)
      roundTrip(16'h1 << s, 32'h0000_0100 + 32'(s) * 32'h40, s[0], s[1]);
    // multi-register patterns, R8 pokes included
    roundTrip(16'hFFFF, 32'h0000_0100, 1'b0, 1'b1);
    roundTrip(16'hFFFF, 32'h0000_0140, 1'b1, 1'b1);
    roundTrip(16'hA5C3, 32'h0000_1080, 1'b1, 1'b0);
    roundTrip(16'h8001, 32'h0000_00C0, 1'b0, 1'b1);
    roundTrip(16'h7FFE, 32'h0000_0100, 1'b1, 1'b1);
    roundTrip(16'h0F00, 32'hFFFF_FFC0, 1'b0, 1'b0);
    roundTrip(16'h3C5A, 32'h0000_0200, 1'b1, 1'b1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule